// File: doc/BRIEF.md
# DRAM Chip-Select Row Decoder

This block maps a physical byte address onto one of eight memory chip-select rows. Software loads eight cumulative row-top values and one 32-bit attribute word through a plain register-write port. Each row-top value counts memory in fixed units: 64 MiB when the controller runs one channel and 128 MiB when it runs two. A row starts at the top of the row below it and ends one page short of its own top. A row whose top equals the one below it holds no memory.

Lookups arrive on a valid/ready stream and leave one cycle later on a second valid/ready stream. Each result gives the row index, a hit flag, an out-of-range flag, the row's device width and the error-correction mode that applies to it. The ECC mode depends on the data-integrity enable, the channel mode and the row's device width taken together. A result waits in its output register until it is taken. Back-pressure therefore stops new lookups: a request is accepted only when the output register is empty or is being emptied in the same cycle.

Top module: `dram_row_decoder`

## Requirements
- R1: After reset every row-top value and the attribute word are zero and no response is pending. Any lookup made before configuration reports out-of-range, no hit and row 0.
- R2: A write with `cfg_sel` 0 to 7 loads `cfg_wdata[7:0]` into that row's top value. A write with `cfg_sel` = 8 loads the whole 32-bit attribute word. Writes with `cfg_sel` from 9 to 15 change nothing.
- R3: A row-top value counts in units of 2^26 bytes in single-channel mode and 2^27 bytes in dual-channel mode. Addresses are compared at 4 KiB page granularity.
- R4: Row i hits when the address is at least the top of row i-1 (zero for row 0) and below the top of row i. When several rows match, the lowest-numbered one is reported.
- R5: A row whose top equals the top of the row below it never hits.
- R6: An address at or above the top of row 7 gives out-of-range = 1, hit = 0, row = 0, x4 = 0 and ECC mode none. A response never has hit and out-of-range both set.
- R7: The device width of row i is in attribute bits [4i+3:4i+2]. The value 2'b10 reports x4 (`rsp_x4` = 1). Every other value reports x8. Without a hit, `rsp_x4` is 0.
- R8: `rsp_ecc` is encoded 0 = none, 1 = SECDED, 2 = 4-bit symbol correction. It is 0 without a hit or when the integrity enable is low. It is 2 on a hit with dual-channel mode and an x4 row. It is 1 on any other hit.
- R9: Dual-channel mode applies exactly when `chan_cfg[1:0]` = 2'b11. `chan_cfg[2]` has no effect.
- R10: `req_ready` equals (no response pending) or `rsp_ready`. An accepted request yields `rsp_valid` on the next cycle. A response held with `rsp_ready` low keeps all its fields unchanged.
- R11: The channel mode, the integrity enable and the register values are sampled in the cycle the request is accepted. A configuration write in that same cycle affects only later lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select: 0-7 row tops, 8 attribute word |
| cfg_wdata | input | 32 | Write data |
| chan_cfg | input | 3 | Channel configuration field |
| integrity_en | input | 1 | Data-integrity (ECC) enable |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted when high with req_valid |
| req_addr | input | 36 | Physical byte address to decode |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_row | output | 3 | Row index of the hit |
| rsp_hit | output | 1 | Address falls inside a populated row |
| rsp_oor | output | 1 | Address at or above total installed memory |
| rsp_x4 | output | 1 | Hit row uses x4 devices |
| rsp_ecc | output | 2 | ECC mode of the hit row |

## Verification
Three situations are hard to reach from the ports: two rows matching at once, a write racing a lookup, and a request waiting while a response is held. Two rows only overlap when the row-top values are not ascending. The bench loads such values on purpose and then checks that the lower row is reported. It also asserts a configuration write and a request acceptance in the same cycle, then shows that the old value was used and the new one applies from the next lookup on. Finally it holds `rsp_ready` low while a second request waits. It checks that the first result stays frozen and that the second is accepted in the very cycle the first is taken.

// File: rtl/dram_rowdec_pkg.sv
package dram_rowdec_pkg;

  typedef enum logic [1:0] {
    ECC_NONE   = 2'd0,
    ECC_SECDED = 2'd1,
    ECC_SYMBOL = 2'd2
  } ecc_mode_e;

  localparam logic [1:0] WIDTH_CODE_X4 = 2'b10;
  localparam logic [1:0] CHAN_DUAL_CODE = 2'b11;

endpackage

// File: rtl/dram_rowdec_regs.sv
module dram_rowdec_regs #(
  parameter int NUM_ROWS = 8,
  parameter int BND_W    = 8,
  parameter int SEL_W    = 4,
  parameter int CFG_DW   = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [SEL_W-1:0]          cfg_sel,
  input  logic [CFG_DW-1:0]         cfg_wdata,
  output logic [NUM_ROWS*BND_W-1:0] bnd_flat,
  output logic [CFG_DW-1:0]         attr_word
);

  localparam logic [SEL_W-1:0] ATTR_SEL = SEL_W'(NUM_ROWS);

  // one byte-wide top register per row, each with its own decoded strobe
  for (genvar g = 0; g < NUM_ROWS; g++) begin : g_top
    logic             wr_en;
    logic [BND_W-1:0] top_q;

    assign wr_en = cfg_we && (cfg_sel == SEL_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        top_q <= '0;
      end else if (wr_en) begin
        top_q <= cfg_wdata[BND_W-1:0];
      end
    end

    assign bnd_flat[g*BND_W +: BND_W] = top_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attr_word <= '0;
    end else if (cfg_we && (cfg_sel == ATTR_SEL)) begin
      attr_word <= cfg_wdata;
    end
  end

endmodule

// File: rtl/dram_rowdec_match.sv
module dram_rowdec_match #(
  parameter int NUM_ROWS  = 8,
  parameter int BND_W     = 8,
  parameter int PAGE_W    = 24,
  parameter int UNIT_SHFT = 14,
  parameter int ROW_W     = 3
) (
  input  logic [PAGE_W-1:0]         page,
  input  logic                      dual,
  input  logic [NUM_ROWS*BND_W-1:0] bnd_flat,
  output logic                      hit,
  output logic                      oor,
  output logic [ROW_W-1:0]          row
);

  localparam int TOP_W = BND_W + UNIT_SHFT + 1;
  localparam int CMP_W = ((PAGE_W > TOP_W) ? PAGE_W : TOP_W) + 1;

  logic [CMP_W-1:0]    page_ext;
  logic [CMP_W-1:0]    top_pg [NUM_ROWS];
  logic [NUM_ROWS-1:0] in_row;
  logic [ROW_W-1:0]    first_row;

  assign page_ext = CMP_W'(page);

  // scale every row top to pages and compare in parallel
  for (genvar g = 0; g < NUM_ROWS; g++) begin : g_cmp
    logic [BND_W-1:0] top_units;
    assign top_units = bnd_flat[g*BND_W +: BND_W];
    assign top_pg[g] = dual ? (CMP_W'(top_units) << (UNIT_SHFT + 1))
                            : (CMP_W'(top_units) << UNIT_SHFT);
    if (g == 0) begin : g_base
      assign in_row[g] = page_ext < top_pg[g];
    end else begin : g_upper
      assign in_row[g] = (page_ext >= top_pg[g-1]) && (page_ext < top_pg[g]);
    end
  end

  // lowest matching row takes priority
  always_comb begin
    first_row = '0;
    for (int i = NUM_ROWS - 1; i >= 0; i--) begin
      if (in_row[i]) begin
        first_row = ROW_W'(i);
      end
    end
  end

  assign oor = page_ext >= top_pg[NUM_ROWS-1];
  assign hit = (|in_row) && !oor;
  assign row = hit ? first_row : '0;

endmodule

// File: rtl/dram_rowdec_attr.sv
module dram_rowdec_attr
  import dram_rowdec_pkg::*;
#(
  parameter int NUM_ROWS = 8,
  parameter int ROW_W    = 3,
  parameter int CFG_DW   = 32
) (
  input  logic [CFG_DW-1:0] attr_word,
  input  logic [ROW_W-1:0]  row,
  input  logic              hit,
  input  logic              dual,
  input  logic              ecc_on,
  output logic              x4,
  output ecc_mode_e         ecc
);

  logic [NUM_ROWS-1:0] row_is_x4;

  for (genvar g = 0; g < NUM_ROWS; g++) begin : g_width
    assign row_is_x4[g] = attr_word[4*g+2 +: 2] == WIDTH_CODE_X4;
  end

  assign x4 = hit && row_is_x4[row];

  always_comb begin
    if (!hit || !ecc_on) begin
      ecc = ECC_NONE;
    end else if (dual && x4) begin
      ecc = ECC_SYMBOL;
    end else begin
      ecc = ECC_SECDED;
    end
  end

endmodule

// File: rtl/dram_row_decoder.sv
module dram_row_decoder
  import dram_rowdec_pkg::*;
#(
  parameter int NUM_ROWS   = 8,
  parameter int BND_W      = 8,
  parameter int ADDR_W     = 36,
  parameter int PAGE_SHIFT = 12,
  parameter int UNIT_LOG2  = 26
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [$clog2(NUM_ROWS+1)-1:0]   cfg_sel,
  input  logic [4*NUM_ROWS-1:0]           cfg_wdata,
  input  logic [2:0]                      chan_cfg,
  input  logic                            integrity_en,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic [ADDR_W-1:0]               req_addr,
  output logic                            rsp_valid,
  input  logic                            rsp_ready,
  output logic [$clog2(NUM_ROWS)-1:0]     rsp_row,
  output logic                            rsp_hit,
  output logic                            rsp_oor,
  output logic                            rsp_x4,
  output logic [1:0]                      rsp_ecc
);

  localparam int SEL_W     = $clog2(NUM_ROWS + 1);
  localparam int ROW_W     = $clog2(NUM_ROWS);
  localparam int CFG_DW    = 4 * NUM_ROWS;
  localparam int PAGE_W    = ADDR_W - PAGE_SHIFT;
  localparam int UNIT_SHFT = UNIT_LOG2 - PAGE_SHIFT;

  logic [NUM_ROWS*BND_W-1:0] bnd_flat;
  logic [CFG_DW-1:0]         attr_word;
  logic                      dual;
  logic                      c_hit, c_oor, c_x4;
  logic [ROW_W-1:0]          c_row;
  ecc_mode_e                 c_ecc;
  logic                      req_fire;
  logic                      unused_bits;

  assign unused_bits = ^{req_addr[PAGE_SHIFT-1:0], chan_cfg[2]};
  assign dual        = chan_cfg[1:0] == CHAN_DUAL_CODE;

  dram_rowdec_regs #(
    .NUM_ROWS (NUM_ROWS),
    .BND_W    (BND_W),
    .SEL_W    (SEL_W),
    .CFG_DW   (CFG_DW)
  ) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .bnd_flat  (bnd_flat),
    .attr_word (attr_word)
  );

  dram_rowdec_match #(
    .NUM_ROWS  (NUM_ROWS),
    .BND_W     (BND_W),
    .PAGE_W    (PAGE_W),
    .UNIT_SHFT (UNIT_SHFT),
    .ROW_W     (ROW_W)
  ) match_i (
    .page     (req_addr[ADDR_W-1:PAGE_SHIFT]),
    .dual     (dual),
    .bnd_flat (bnd_flat),
    .hit      (c_hit),
    .oor      (c_oor),
    .row      (c_row)
  );

  dram_rowdec_attr #(
    .NUM_ROWS (NUM_ROWS),
    .ROW_W    (ROW_W),
    .CFG_DW   (CFG_DW)
  ) attr_i (
    .attr_word (attr_word),
    .row       (c_row),
    .hit       (c_hit),
    .dual      (dual),
    .ecc_on    (integrity_en),
    .x4        (c_x4),
    .ecc       (c_ecc)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign req_fire  = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_row   <= '0;
      rsp_hit   <= 1'b0;
      rsp_oor   <= 1'b0;
      rsp_x4    <= 1'b0;
      rsp_ecc   <= ECC_NONE;
    end else if (req_fire) begin
      rsp_valid <= 1'b1;
      rsp_row   <= c_row;
      rsp_hit   <= c_hit;
      rsp_oor   <= c_oor;
      rsp_x4    <= c_x4;
      rsp_ecc   <= c_ecc;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/dram_row_decoder_chk.sv
module dram_row_decoder_chk #(
  parameter int ROW_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [ROW_W-1:0] rsp_row,
  input logic             rsp_hit,
  input logic             rsp_oor,
  input logic             rsp_x4,
  input logic [1:0]       rsp_ecc
);

  AST_HIT_OOR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_hit && rsp_oor)); // R6

  AST_MISS_NEUTRAL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_row == '0 && !rsp_x4 && rsp_ecc == 2'd0)); // R6

  AST_SYMBOL_NEEDS_X4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ecc == 2'd2) |-> (rsp_x4 && rsp_hit)); // R8

  AST_ECC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_ecc != 2'd3)); // R8

  AST_STALL_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready); // R10

  AST_ACCEPT_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R10

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_row) && $stable(rsp_hit)
      && $stable(rsp_oor) && $stable(rsp_x4) && $stable(rsp_ecc))); // R10

endmodule

bind dram_row_decoder dram_row_decoder_chk #(
  .ROW_W ($clog2(NUM_ROWS))
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_row   (rsp_row),
  .rsp_hit   (rsp_hit),
  .rsp_oor   (rsp_oor),
  .rsp_x4    (rsp_x4),
  .rsp_ecc   (rsp_ecc)
);

// File: tb/dram_row_decoder_tb_top.sv
`timescale 1ns/1ps
module dram_row_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [2:0]  chan_cfg = 3'b001;
  logic        integrity_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [35:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [2:0]  rsp_row;
  logic        rsp_hit, rsp_oor, rsp_x4;
  logic [1:0]  rsp_ecc;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  dram_row_decoder dut_i (
    .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_sel (cfg_sel),
    .cfg_wdata (cfg_wdata), .chan_cfg (chan_cfg), .integrity_en (integrity_en),
    .req_valid (req_valid), .req_ready (req_ready), .req_addr (req_addr),
    .rsp_valid (rsp_valid), .rsp_ready (rsp_ready), .rsp_row (rsp_row),
    .rsp_hit (rsp_hit), .rsp_oor (rsp_oor), .rsp_x4 (rsp_x4), .rsp_ecc (rsp_ecc)
  );

  // {chan[47:45], ien[44], addr[43:8], hit[7], oor[6], row[5:3], x4[2], ecc[1:0]}
  // tops 2,2,4,5,5,5,8,8; rows 2 and 6 are x4, rows 0 and 3 are x8
  localparam int NVEC = 14;
  localparam logic [47:0] VEC [NVEC] = '{
    {3'b001, 1'b1, 36'h0_0000_0000, 1'b1, 1'b0, 3'd0, 1'b0, 2'd1},
    {3'b100, 1'b1, 36'h0_07FF_FFFF, 1'b1, 1'b0, 3'd0, 1'b0, 2'd1},
    {3'b001, 1'b1, 36'h0_0800_0000, 1'b1, 1'b0, 3'd2, 1'b1, 2'd1},
    {3'b011, 1'b1, 36'h0_0800_0000, 1'b1, 1'b0, 3'd0, 1'b0, 2'd1},
    {3'b111, 1'b1, 36'h0_1000_0000, 1'b1, 1'b0, 3'd2, 1'b1, 2'd2},
    {3'b011, 1'b0, 36'h0_1000_0000, 1'b1, 1'b0, 3'd2, 1'b1, 2'd0},
    {3'b100, 1'b1, 36'h0_1000_0000, 1'b1, 1'b0, 3'd3, 1'b0, 2'd1},
    {3'b001, 1'b1, 36'h0_1400_0000, 1'b1, 1'b0, 3'd6, 1'b1, 2'd1},
    {3'b011, 1'b1, 36'h0_2800_0000, 1'b1, 1'b0, 3'd6, 1'b1, 2'd2},
    {3'b001, 1'b1, 36'h0_1FFF_FFFF, 1'b1, 1'b0, 3'd6, 1'b1, 2'd1},
    {3'b001, 1'b1, 36'h0_2000_0000, 1'b0, 1'b1, 3'd0, 1'b0, 2'd0},
    {3'b111, 1'b1, 36'h0_2000_0000, 1'b1, 1'b0, 3'd3, 1'b0, 2'd1},
    {3'b011, 1'b1, 36'h0_4000_0000, 1'b0, 1'b1, 3'd0, 1'b0, 2'd0},
    {3'b001, 1'b1, 36'hF_FFFF_FFFF, 1'b0, 1'b1, 3'd0, 1'b0, 2'd0}
  };

  task automatic expect_rsp(input string tag, input logic hit, input logic oor,
                            input logic [2:0] row, input logic x4, input logic [1:0] ecc);
    checks++;
    if (!(rsp_valid === 1'b1 && rsp_hit === hit && rsp_oor === oor &&
          rsp_row === row && rsp_x4 === x4 && rsp_ecc === ecc)) begin
      fails++;
      $display("FAIL %s: got v=%b hit=%b oor=%b row=%0d x4=%b ecc=%0d exp v=1 hit=%b oor=%b row=%0d x4=%b ecc=%0d",
               tag, rsp_valid, rsp_hit, rsp_oor, rsp_row, rsp_x4, rsp_ecc,
               hit, oor, row, x4, ecc);
    end
  endtask

  task automatic cfg_write(input logic [3:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // request accepted at next posedge, result sampled at the following negedge
  task automatic lookup(input logic [2:0] ch, input logic ien, input logic [35:0] a);
    @(negedge clk);
    chan_cfg = ch; integrity_en = ien; req_addr = a; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got run still active, exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R10: idle after reset
    checks++;
    if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1: got rsp_valid=%b req_ready=%b exp 0 1", rsp_valid, req_ready);
    end
    lookup(3'b001, 1'b1, 36'h0_0000_0000);
    expect_rsp("R1 empty single", 1'b0, 1'b1, 3'd0, 1'b0, 2'd0);
    lookup(3'b011, 1'b1, 36'h0_1234_5000);
    expect_rsp("R1 empty dual", 1'b0, 1'b1, 3'd0, 1'b0, 2'd0);

    // R2: configuration
    cfg_write(4'd0, 32'h2);
    cfg_write(4'd1, 32'h2);
    cfg_write(4'd2, 32'h4);
    cfg_write(4'd3, 32'h5);
    cfg_write(4'd4, 32'h5);
    cfg_write(4'd5, 32'h5);
    cfg_write(4'd6, 32'h8);
    cfg_write(4'd7, 32'hFFFF_FF08);
    cfg_write(4'd8, 32'h0800_C804);
    // R2: selects above 8 are ignored (10 would alias row 2 if decoded on low bits)
    cfg_write(4'd10, 32'h0);
    cfg_write(4'd15, 32'h0);

    // R3 R4 R5 R6 R7 R8 R9 table
    for (int i = 0; i < NVEC; i++) begin
      lookup(VEC[i][47:45], VEC[i][44], VEC[i][43:8]);
      expect_rsp($sformatf("vector %0d (R2 R3 R4 R5 R6 R7 R8 R9)", i),
                 VEC[i][7], VEC[i][6], VEC[i][5:3], VEC[i][2], VEC[i][1:0]);
    end

    // R10: stall holds the result and blocks a waiting request
    @(negedge clk);
    rsp_ready = 1'b0;
    chan_cfg = 3'b001; integrity_en = 1'b1; req_addr = 36'h0; req_valid = 1'b1;
    @(negedge clk);
    req_addr = 36'h0_0800_0000;
    @(negedge clk);
    @(negedge clk);
    expect_rsp("R10 held under stall", 1'b1, 1'b0, 3'd0, 1'b0, 2'd1);
    checks++;
    if (req_ready !== 1'b0) begin
      fails++;
      $display("FAIL R10: got req_ready=%b exp 0", req_ready);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    expect_rsp("R10 waiting request taken on release", 1'b1, 1'b0, 3'd2, 1'b1, 2'd1);
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R10: got rsp_valid=%b exp 0 after drain", rsp_valid);
    end

    // R11: write in the acceptance cycle affects only later lookups
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 4'd0; cfg_wdata = 32'h0;
    chan_cfg = 3'b001; integrity_en = 1'b1; req_addr = 36'h0; req_valid = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    expect_rsp("R11 old top used", 1'b1, 1'b0, 3'd0, 1'b0, 2'd1);
    // R5: row 0 now empty, address 0 falls in row 1 (x8)
    lookup(3'b001, 1'b1, 36'h0);
    expect_rsp("R5 emptied row skipped", 1'b1, 1'b0, 3'd1, 1'b0, 2'd1);

    // R4: overlapping rows, lowest wins (tops 4,2,4,...)
    cfg_write(4'd0, 32'h4);
    lookup(3'b001, 1'b1, 36'h0_0C00_0000);
    expect_rsp("R4 lowest of overlapping rows", 1'b1, 1'b0, 3'd0, 1'b0, 2'd1);
    lookup(3'b011, 1'b1, 36'h0_1C00_0000);
    expect_rsp("R4 dual overlap", 1'b1, 1'b0, 3'd0, 1'b0, 2'd1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule